// File: doc/BRIEF.md
# Second-Stage Access Permission Checker

This block sits behind a second-stage address lookup and decides whether the access that produced the lookup may go ahead. It receives the permission bits and the execute-never bit returned by the lookup, the memory type of the target (device or normal) and the kind of the original access. It also receives a flag that marks accesses made on behalf of a first-stage table walk, an alignment flag and a control bit that enables protected walks. From these it returns a fault flag, a fault class and the read/write sense that a fault report should carry.

Table-walk accesses are handled specially. Whatever the original access kind was, a walk access is always checked for read permission. When protected walks are enabled, a walk access that lands on device memory faults even if its permissions are fine. The checks run in a fixed priority order: alignment first, then permission, then protected walk. Only the first fault found is reported. The inputs are captured on a valid strobe, and the registered verdict appears exactly one cycle later.

Top module: `s2_perm_checker`

## Requirements
- R1: A verdict appears on `out_valid_o` exactly one clock after `in_valid` is high. While `out_valid_o` is low, `fault_o`, `fault_class_o` and `fault_write_o` are all 0.
- R2: The encodings are fixed. Access kind: 0 is instruction fetch, 1 is data read, 2 is data write and 3 is treated as a data read. Read permission is `ap_i[1]`, write permission is `ap_i[2]`, and `ap_i[0]` has no effect. Fault class: 0 is none, 1 is alignment and 2 is permission.
- R3: A non-walk instruction fetch faults with class 2 exactly when `xn_i` is 1. The fault is reported with `fault_write_o` = 0, and the permission bits have no effect on it.
- R4: A non-walk data write faults with class 2 exactly when `ap_i[2]` is 0, and the fault is reported with `fault_write_o` = 1.
- R5: Non-walk reads, and every walk access, fault with class 2 exactly when `ap_i[1]` is 0. The fault is reported with `fault_write_o` = 0.
- R6: A non-walk access that is not a fetch, is unaligned (`aligned_i` = 0) and targets device memory raises class 1. The write flag is set for a data write. This check wins over every permission outcome.
- R7: A walk access that has no permission fault, targets device memory and has `ptw_en_i` = 1 raises class 2, reported as a read.
- R8: Walk accesses never raise an alignment fault, whatever `aligned_i` is. A walk whose original kind is a fetch or a write is still checked as a read, so `xn_i` and `ap_i[2]` have no effect on it.
- R9: `ptw_en_i` has no effect on non-walk accesses or on accesses to normal memory.
- R10: After reset, and until the first valid input, `out_valid_o` and all fault outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; the other inputs are sampled while it is high |
| ap_i | input | 3 | Permission bits: [1] read, [2] write, [0] unused |
| xn_i | input | 1 | Execute-never |
| dev_i | input | 1 | 1 when the target is device memory |
| kind_i | input | 2 | Access kind (see R2) |
| walk_i | input | 1 | Access made for a first-stage table walk |
| aligned_i | input | 1 | 1 when the access is aligned |
| ptw_en_i | input | 1 | Protected-walk enable |
| out_valid_o | output | 1 | Verdict valid, one cycle after `in_valid` |
| fault_o | output | 1 | A fault was found |
| fault_class_o | output | 2 | 0 none, 1 alignment, 2 permission |
| fault_write_o | output | 1 | The fault is reported as a write |

## Verification
The bench sweeps every combination of the ten input bits. Idle cycles are placed between strobes so that outputs left standing would show up as stale verdicts.

Several corner cases are targeted:
- A walk whose original kind is a write or a fetch. A design that forgot the walk override would report a write fault, or would test execute-never instead of read permission.
- An unaligned device write that also lacks write permission. A design with the priority reversed would report class 2 instead of 1.
- An unaligned walk to device memory. A design that applied the alignment check to walk accesses would raise a false alignment fault.
- Protected-walk enable asserted on non-walk device accesses. This exposes a design that applied the walk check too broadly.

// File: rtl/s2pc_pkg.sv
package s2pc_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RDALT = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ALIGN = 2'd1,
    CLS_PERM  = 2'd2
  } fault_cls_e;

  typedef enum logic [1:0] {
    MODE_EXEC  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_READ  = 2'd2
  } chk_mode_e;

  // Which permission test applies: walks are always reads.
  function automatic chk_mode_e pick_mode(input acc_kind_e kind, input logic walk);
    if (walk)                    return MODE_READ;
    else if (kind == KIND_FETCH) return MODE_EXEC;
    else if (kind == KIND_WRITE) return MODE_WRITE;
    else                         return MODE_READ;
  endfunction

  // Unaligned non-fetch device access outside a walk.
  function automatic logic align_violation(input acc_kind_e kind, input logic walk,
                                           input logic aligned, input logic dev);
    return !walk && !aligned && dev && (kind != KIND_FETCH);
  endfunction

endpackage

// File: rtl/s2pc_mode_sel.sv
module s2pc_mode_sel
  import s2pc_pkg::*;
(
  input  acc_kind_e kind,
  input  logic      walk,
  output chk_mode_e mode
);
  always_comb mode = pick_mode(kind, walk);
endmodule

// File: rtl/s2pc_perm_eval.sv
module s2pc_perm_eval
  import s2pc_pkg::*;
#(
  parameter int AP_W   = 3,
  parameter int RD_BIT = 1,
  parameter int WR_BIT = 2
) (
  input  chk_mode_e        mode,
  input  logic [AP_W-1:0]  ap,
  input  logic             xn,
  output logic             perm_fail,
  output logic             perm_wr
);
  always_comb begin
    perm_fail = 1'b0;
    perm_wr   = 1'b0;
    unique case (mode)
      MODE_EXEC:  perm_fail = xn;
      MODE_WRITE: begin
        perm_fail = !ap[WR_BIT];
        perm_wr   = 1'b1;
      end
      default:    perm_fail = !ap[RD_BIT];
    endcase
  end
endmodule

// File: rtl/s2pc_fault_pick.sv
module s2pc_fault_pick
  import s2pc_pkg::*;
(
  input  logic       align_fail,
  input  logic       align_wr,
  input  logic       perm_fail,
  input  logic       perm_wr,
  input  logic       ptw_fail,
  output logic       fault,
  output fault_cls_e cls,
  output logic       wr
);
  always_comb begin
    fault = 1'b1;
    cls   = CLS_NONE;
    wr    = 1'b0;
    if (align_fail) begin
      cls = CLS_ALIGN;
      wr  = align_wr;
    end else if (perm_fail) begin
      cls = CLS_PERM;
      wr  = perm_wr;
    end else if (ptw_fail) begin
      cls = CLS_PERM;
      wr  = 1'b0;
    end else begin
      fault = 1'b0;
    end
  end
endmodule

// File: rtl/s2_perm_checker.sv
module s2_perm_checker
  import s2pc_pkg::*;
#(
  parameter int AP_W   = 3,
  parameter int RD_BIT = 1,
  parameter int WR_BIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [AP_W-1:0] ap_i,
  input  logic            xn_i,
  input  logic            dev_i,
  input  logic [1:0]      kind_i,
  input  logic            walk_i,
  input  logic            aligned_i,
  input  logic            ptw_en_i,
  output logic            out_valid_o,
  output logic            fault_o,
  output logic [1:0]      fault_class_o,
  output logic            fault_write_o
);

  acc_kind_e  kind_w;
  chk_mode_e  mode_w;
  logic       align_fail_w, align_wr_w;
  logic       perm_fail_w, perm_wr_w;
  logic       ptw_fail_w;
  logic       fault_w, wr_w;
  fault_cls_e cls_w;

  assign kind_w       = acc_kind_e'(kind_i);
  assign align_fail_w = align_violation(kind_w, walk_i, aligned_i, dev_i);
  assign align_wr_w   = (kind_w == KIND_WRITE);
  assign ptw_fail_w   = walk_i && dev_i && ptw_en_i;

  s2pc_mode_sel u_mode (
    .kind (kind_w),
    .walk (walk_i),
    .mode (mode_w)
  );

  s2pc_perm_eval #(
    .AP_W   (AP_W),
    .RD_BIT (RD_BIT),
    .WR_BIT (WR_BIT)
  ) u_perm (
    .mode      (mode_w),
    .ap        (ap_i),
    .xn        (xn_i),
    .perm_fail (perm_fail_w),
    .perm_wr   (perm_wr_w)
  );

  s2pc_fault_pick u_pick (
    .align_fail (align_fail_w),
    .align_wr   (align_wr_w),
    .perm_fail  (perm_fail_w),
    .perm_wr    (perm_wr_w),
    .ptw_fail   (ptw_fail_w),
    .fault      (fault_w),
    .cls        (cls_w),
    .wr         (wr_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o   <= 1'b0;
      fault_o       <= 1'b0;
      fault_class_o <= 2'd0;
      fault_write_o <= 1'b0;
    end else begin
      out_valid_o   <= in_valid;
      fault_o       <= in_valid && fault_w;
      fault_class_o <= in_valid ? cls_w : 2'd0;
      fault_write_o <= in_valid && wr_w;
    end
  end

endmodule

// File: rtl/s2_perm_checker_sva.sv
module s2_perm_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       walk_i,
  input logic       dev_i,
  input logic       ptw_en_i,
  input logic [1:0] kind_i,
  input logic       align_fail_w,
  input logic       perm_fail_w,
  input logic       out_valid_o,
  input logic       fault_o,
  input logic [1:0] fault_class_o,
  input logic       fault_write_o
);

  // R1: verdict one cycle after strobe
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid_o);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> (!fault_o && fault_class_o == 2'd0 && !fault_write_o));

  // R2: a class is shown exactly when a fault is flagged
  a_r2_class: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o == (fault_class_o != 2'd0));

  // R6: alignment outranks permission
  a_r6_align_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && align_fail_w) |=> (fault_class_o == 2'd1));

  // R5 and R8: walk faults are never reported as writes or alignment faults
  a_r8_walk_read: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && walk_i) |=> (!fault_write_o && fault_class_o != 2'd1));

  // R7: protected walk on device memory always faults
  a_r7_ptw: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && walk_i && dev_i && ptw_en_i) |=> (fault_o && fault_class_o == 2'd2));

  // R3: a non-walk fetch never produces an alignment fault
  a_r3_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !walk_i && kind_i == 2'd0) |=> (fault_class_o != 2'd1 && !fault_write_o));

  // R4: permission failure leads to a permission fault unless alignment won
  a_r4_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && perm_fail_w && !align_fail_w) |=> (fault_class_o == 2'd2));

endmodule

bind s2_perm_checker s2_perm_checker_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .walk_i        (walk_i),
  .dev_i         (dev_i),
  .ptw_en_i      (ptw_en_i),
  .kind_i        (kind_i),
  .align_fail_w  (align_fail_w),
  .perm_fail_w   (perm_fail_w),
  .out_valid_o   (out_valid_o),
  .fault_o       (fault_o),
  .fault_class_o (fault_class_o),
  .fault_write_o (fault_write_o)
);

// File: tb/s2_perm_checker_tb.sv
module s2_perm_checker_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] ap_i = '0;
  logic       xn_i = 1'b0, dev_i = 1'b0, walk_i = 1'b0, aligned_i = 1'b1, ptw_en_i = 1'b0;
  logic [1:0] kind_i = '0;
  logic       out_valid_o, fault_o, fault_write_o;
  logic [1:0] fault_class_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected values for the current output cycle
  bit    e_v = 0, e_f = 0, e_w = 0;
  int    e_c = 0;
  string e_tag = "R10";

  always #2 clk = ~clk;  // 250 MHz

  s2_perm_checker u_dut (
    .clk, .rst_n, .in_valid, .ap_i, .xn_i, .dev_i, .kind_i, .walk_i,
    .aligned_i, .ptw_en_i, .out_valid_o, .fault_o, .fault_class_o, .fault_write_o
  );

  // Reference model, from the requirements.
  task automatic model(input bit v, input bit [2:0] ap, input bit xn, input bit dev,
                       input int kind, input bit walk, input bit al, input bit ptw);
    bit exec, wrt;
    e_v = v; e_f = 0; e_c = 0; e_w = 0;
    if (!v) begin e_tag = "R1"; return; end
    exec = !walk && kind == 0;
    wrt  = !walk && kind == 2;
    if (!walk && kind != 0 && dev && !al) begin
      e_f = 1; e_c = 1; e_w = (kind == 2); e_tag = "R6";
    end else if (exec) begin
      e_tag = "R3";
      if (xn) begin e_f = 1; e_c = 2; end
    end else if (wrt) begin
      e_tag = "R4";
      if (!ap[2]) begin e_f = 1; e_c = 2; e_w = 1; end
    end else if (!ap[1]) begin
      e_f = 1; e_c = 2; e_tag = walk ? "R8" : "R5";
    end else if (walk) begin
      e_tag = "R7";
      if (dev && ptw) begin e_f = 1; e_c = 2; end
    end else e_tag = ptw ? "R9" : "R5";
  endtask

  task automatic check_now();
    checks++;
    if (out_valid_o !== e_v || fault_o !== e_f || int'(fault_class_o) != e_c ||
        fault_write_o !== e_w) begin
      fails++;
      $display("FAIL %s: got v=%0b f=%0b c=%0d w=%0b expected v=%0b f=%0b c=%0d w=%0b",
               e_tag, out_valid_o, fault_o, fault_class_o, fault_write_o, e_v, e_f, e_c, e_w);
    end
  endtask

  // Drive on the negedge; result is visible after the next posedge.
  task automatic step(input bit v, input bit [2:0] ap, input bit xn, input bit dev,
                      input int kind, input bit walk, input bit al, input bit ptw);
    in_valid = v; ap_i = ap; xn_i = xn; dev_i = dev; kind_i = kind[1:0];
    walk_i = walk; aligned_i = al; ptw_en_i = ptw;
    @(negedge clk);
    model(v, ap, xn, dev, kind, walk, al, ptw);
    check_now();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    e_tag = "R10";
    check_now();                 // R10 during reset
    rst_n = 1'b1;
    @(negedge clk);
    e_tag = "R10";
    check_now();                 // R10 after reset, no strobe yet

    // Directed corners
    step(1, 3'b000, 0, 1, 2, 0, 0, 0);  // R6 unaligned device write beats perm
    step(1, 3'b110, 0, 0, 2, 1, 1, 0);  // R8 walk write with read perm ok
    step(1, 3'b100, 0, 0, 2, 1, 1, 0);  // R8 walk write checked as read -> fault
    step(1, 3'b110, 1, 0, 0, 1, 1, 0);  // R8 walk fetch ignores xn
    step(1, 3'b110, 0, 1, 1, 1, 0, 1);  // R7 protected walk, unaligned ignored
    step(1, 3'b110, 0, 1, 1, 0, 1, 1);  // R9 ptw has no effect on non-walk
    step(1, 3'b000, 1, 0, 0, 0, 1, 0);  // R3 fetch fault on xn
    step(1, 3'b111, 0, 0, 0, 0, 1, 0);  // R3 fetch ok
    step(1, 3'b001, 0, 0, 3, 0, 1, 0);  // R2 kind 3 as read, ap[0] unused
    step(0, 3'b000, 1, 1, 2, 0, 0, 1);  // R1 idle cycle
    step(1, 3'b000, 0, 1, 0, 0, 0, 0);  // R6 fetch excluded from align

    // Exhaustive sweep with idle gaps
    for (int i = 0; i < 1024; i++) begin
      step(1, i[2:0], i[3], i[4], int'(i[6:5]), i[7], i[8], i[9]);
      if (i % 7 == 0) step(0, i[2:0], i[3], i[4], int'(i[6:5]), i[7], i[8], i[9]);
    end
    step(0, 3'b000, 0, 0, 0, 0, 1, 0);
    done = 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
    end
  end

  initial begin
    wait (done == 1 || ($time > 80000));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule